// File: doc/BRIEF.md
# CPU Interrupt Acceptance Controller

This block works next to an 8-bit processor core with a 16-bit address space. At each instruction boundary the core raises a strobe. The controller then decides whether to enter a non-maskable handler, enter a maskable handler, or let execution carry on. It owns the two interrupt-enable flip-flops (`iff1`, `iff2`) and applies the enable, disable and return-from-non-maskable events that the core's decoder reports. It also keeps the maskable interrupt mode, which is set by the core.

When an entry is accepted, the controller issues a one-cycle `taken` pulse. With it come the return address the core must push, the new program counter and the clock-state cost of the entry. For the table mode the new program counter is a pointer into the vector table, and the core fetches the handler address from it. The controller also drives `pv_flag` with the current `iff2` value. The core copies this bit into the parity/overflow flag when it loads the accumulator from the interrupt or refresh register.

Maskable requests come from several numbered sources, and each source has its own byte on a per-source vector bus. A request pulse is latched as pending until that source is served. The non-maskable request is latched in the same way and clears itself when it is accepted.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A maskable request is accepted only while `iff1` is 1. While `iff1` is 0 the request stays pending and produces no `taken`.
- R2: A pending non-maskable request wins over every pending maskable request and is accepted whatever the value of `iff1`. Maskable requests that were pending at that time stay pending.
- R3: Accepting the non-maskable request clears `iff1` and leaves `iff2` as it was. Its pending latch clears, so one request gives exactly one entry.
- R4: A non-maskable entry reports `new_pc` = 0x0066, `entry_cost` = 11 and `took_nmi` = 1.
- R5: Accepting any maskable request clears both `iff1` and `iff2`.
- R6: `ei_exec` sets both enable flops to 1. `di_exec` clears both.
- R7: The return address `push_data` is `cur_pc`+1 when `cur_opcode` is 0x76 (HALT) and `stop_on_halt` is 0. In every other case it is `cur_pc`.
- R8: `im_set` with `im_value` 0, 1 or 2 selects the maskable mode, and value 3 leaves the mode unchanged. Mode 0 treats the source's byte as a restart opcode, giving `new_pc` = byte[5:3]×8 with cost 13. Mode 1 gives `new_pc` = 0x0038 with cost 13. Mode 2 gives `new_pc` = {`i_reg`, byte} with `vec_fetch` = 1 and cost 19. `vec_fetch` is 0 in the other modes.
- R9: When several maskable sources are pending, the lowest-numbered one is served and only its pending bit is cleared.
- R10: Acceptance happens only at an edge where `boundary` is 1. `taken`, `push_req` and the entry outputs appear in the cycle after that edge, and `taken` drops again in the following cycle.
- R11: `retn_exec` copies `iff2` into `iff1`.
- R12: After reset both enable flops are 0, the mode is 0, nothing is pending and `taken` is 0.
- R13: `pv_flag` always equals `iff2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| boundary | input | 1 | Instruction-boundary strobe |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_req | input | NSRC | Maskable request pulses, one per source |
| vec_data | input | NSRC*8 | Vector byte of each source; source k uses bits [8k+7:8k] |
| ei_exec | input | 1 | Enable-interrupts instruction executed |
| di_exec | input | 1 | Disable-interrupts instruction executed |
| retn_exec | input | 1 | Return-from-non-maskable executed |
| im_set | input | 1 | Mode-set instruction executed |
| im_value | input | 2 | Requested mode |
| cur_pc | input | ADDR_W | Program counter at the boundary |
| cur_opcode | input | 8 | Opcode byte at `cur_pc` |
| stop_on_halt | input | 1 | Configuration: do not step over a HALT |
| i_reg | input | 8 | Interrupt vector base register |
| taken | output | 1 | One-cycle entry pulse |
| took_nmi | output | 1 | The entry in this cycle is non-maskable |
| push_req | output | 1 | Request to push `push_data` |
| push_data | output | ADDR_W | Return address to push |
| new_pc | output | ADDR_W | Handler address, or table pointer when `vec_fetch` is 1 |
| vec_fetch | output | 1 | `new_pc` must be read from the vector table |
| entry_cost | output | 5 | Clock states charged for the entry |
| iff1 | output | 1 | First enable flop |
| iff2 | output | 1 | Second enable flop |
| pv_flag | output | 1 | Value for the parity/overflow flag copy |
| int_mode | output | 2 | Current maskable mode |

## Verification
A request pulse is latched at one edge. It can be accepted at the first later edge where `boundary` is high, and all entry outputs and enable-flop changes are visible in the cycle after that edge. Enable, disable, return and mode events also take effect one edge after they are driven. The bench drives every input on the falling edge and holds it across exactly one rising edge. It reads results at the next falling edge, so each check falls in the first cycle in which the result is due. The sweep covers every mode, every source and both opcode cases. The expected handler address, cost and return address are all computed arithmetically in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    IM_RST   = 2'd0,
    IM_FIXED = 2'd1,
    IM_TABLE = 2'd2
  } im_mode_e;

  localparam int COST_W = 5;
  localparam logic [7:0] HALT_OPCODE = 8'h76;
  localparam logic [COST_W-1:0] COST_NMI = 5'd11;
  localparam logic [COST_W-1:0] COST_RST = 5'd13;
  localparam logic [COST_W-1:0] COST_FIXED = 5'd13;
  localparam logic [COST_W-1:0] COST_TABLE = 5'd19;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             nmi_clr,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             irq_clr,
  output logic             nmi_pend,
  output logic             irq_any,
  output logic [IDX_W-1:0] irq_idx
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] clr_vec;
  logic            nmi_q;
  logic            nmi_nxt;
  logic            nmi_en;

  // lowest-numbered pending source
  always_comb begin
    irq_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_q[i]) irq_idx = IDX_W'(i);
    end
  end

  assign irq_any = |pend_q;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic bit_nxt;
      logic bit_en;
      assign clr_vec[g] = irq_clr && (irq_idx == IDX_W'(g));
      always_comb begin
        bit_en  = irq_req[g] | clr_vec[g];
        bit_nxt = irq_req[g] | (pend_q[g] & ~clr_vec[g]);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q[g] <= 1'b0;
        else if (bit_en) pend_q[g] <= bit_nxt;
      end
    end
  endgenerate

  always_comb begin
    nmi_en  = nmi_req | nmi_clr;
    nmi_nxt = nmi_req | (nmi_q & ~nmi_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else if (nmi_en) nmi_q <= nmi_nxt;
  end

  assign nmi_pend = nmi_q;
endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_nmi,
  input  logic     take_irq,
  input  logic     ei_exec,
  input  logic     di_exec,
  input  logic     retn_exec,
  input  logic     im_set,
  input  logic [1:0] im_value,
  output logic     iff1,
  output logic     iff2,
  output im_mode_e mode
);
  logic     f1_q, f2_q, f1_nxt, f2_nxt, f_en;
  im_mode_e mode_q, mode_nxt;
  logic     mode_en;

  // entry wins over instruction events in the same cycle
  always_comb begin
    f1_nxt = f1_q;
    f2_nxt = f2_q;
    if (take_nmi) begin
      f1_nxt = 1'b0;
    end else if (take_irq) begin
      f1_nxt = 1'b0;
      f2_nxt = 1'b0;
    end else if (ei_exec) begin
      f1_nxt = 1'b1;
      f2_nxt = 1'b1;
    end else if (di_exec) begin
      f1_nxt = 1'b0;
      f2_nxt = 1'b0;
    end else if (retn_exec) begin
      f1_nxt = f2_q;
    end
    f_en = take_nmi | take_irq | ei_exec | di_exec | retn_exec;
  end

  always_comb begin
    mode_en  = im_set && (im_value != 2'd3);
    mode_nxt = im_mode_e'(im_value);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_q <= 1'b0;
      f2_q <= 1'b0;
    end else if (f_en) begin
      f1_q <= f1_nxt;
      f2_q <= f2_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= IM_RST;
    else if (mode_en) mode_q <= mode_nxt;
  end

  assign iff1 = f1_q;
  assign iff2 = f2_q;
  assign mode = mode_q;
endmodule

// File: rtl/irqc_vector.sv
module irqc_vector
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038
) (
  input  logic              is_nmi,
  input  im_mode_e          mode,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [7:0]        cur_opcode,
  input  logic              stop_on_halt,
  input  logic [7:0]        i_reg,
  input  logic [7:0]        src_byte,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] target,
  output logic [COST_W-1:0] cost,
  output logic              fetch
);
  logic step_over;

  always_comb begin
    step_over = (cur_opcode == HALT_OPCODE) && !stop_on_halt;
    ret_addr  = step_over ? (cur_pc + ADDR_W'(1)) : cur_pc;
  end

  always_comb begin
    target = NMI_VEC;
    cost   = COST_NMI;
    fetch  = 1'b0;
    if (!is_nmi) begin
      case (mode)
        IM_FIXED: begin
          target = FIXED_VEC;
          cost   = COST_FIXED;
        end
        IM_TABLE: begin
          target = ADDR_W'({i_reg, src_byte});
          cost   = COST_TABLE;
          fetch  = 1'b1;
        end
        default: begin
          target = ADDR_W'({src_byte[5:3], 3'b000});
          cost   = COST_RST;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
  parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              nmi_req,
  input  logic [NSRC-1:0]   irq_req,
  input  logic [NSRC*8-1:0] vec_data,
  input  logic              ei_exec,
  input  logic              di_exec,
  input  logic              retn_exec,
  input  logic              im_set,
  input  logic [1:0]        im_value,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [7:0]        cur_opcode,
  input  logic              stop_on_halt,
  input  logic [7:0]        i_reg,
  output logic              taken,
  output logic              took_nmi,
  output logic              push_req,
  output logic [ADDR_W-1:0] push_data,
  output logic [ADDR_W-1:0] new_pc,
  output logic              vec_fetch,
  output logic [4:0]        entry_cost,
  output logic              iff1,
  output logic              iff2,
  output logic              pv_flag,
  output logic [1:0]        int_mode
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              nmi_pend, irq_any;
  logic [IDX_W-1:0]  irq_idx;
  logic              take_nmi, take_irq, accept;
  logic [7:0]        src_byte;
  im_mode_e          mode;
  logic [ADDR_W-1:0] ret_addr, target;
  logic [COST_W-1:0] cost;
  logic              fetch;

  logic              taken_q, nmi_q, push_q, fetch_q;
  logic [ADDR_W-1:0] push_data_q, new_pc_q;
  logic [COST_W-1:0] cost_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .nmi_req  (nmi_req),
    .nmi_clr  (take_nmi),
    .irq_req  (irq_req),
    .irq_clr  (take_irq),
    .nmi_pend (nmi_pend),
    .irq_any  (irq_any),
    .irq_idx  (irq_idx)
  );

  always_comb begin
    take_nmi = boundary && nmi_pend;
    take_irq = boundary && !nmi_pend && irq_any && iff1;
    accept   = take_nmi | take_irq;
    src_byte = vec_data[irq_idx*8 +: 8];
  end

  irqc_enable u_en (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .take_nmi  (take_nmi),
    .take_irq  (take_irq),
    .ei_exec   (ei_exec),
    .di_exec   (di_exec),
    .retn_exec (retn_exec),
    .im_set    (im_set),
    .im_value  (im_value),
    .iff1      (iff1),
    .iff2      (iff2),
    .mode      (mode)
  );

  irqc_vector #(.ADDR_W(ADDR_W), .NMI_VEC(NMI_VEC), .FIXED_VEC(FIXED_VEC)) u_vec (
    .is_nmi       (take_nmi),
    .mode         (mode),
    .cur_pc       (cur_pc),
    .cur_opcode   (cur_opcode),
    .stop_on_halt (stop_on_halt),
    .i_reg        (i_reg),
    .src_byte     (src_byte),
    .ret_addr     (ret_addr),
    .target       (target),
    .cost         (cost),
    .fetch        (fetch)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      taken_q <= 1'b0;
      nmi_q   <= 1'b0;
      push_q  <= 1'b0;
    end else begin
      taken_q <= accept;
      nmi_q   <= take_nmi;
      push_q  <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      push_data_q <= '0;
      new_pc_q    <= '0;
      cost_q      <= '0;
      fetch_q     <= 1'b0;
    end else if (accept) begin
      push_data_q <= ret_addr;
      new_pc_q    <= target;
      cost_q      <= cost;
      fetch_q     <= fetch;
    end
  end

  assign taken      = taken_q;
  assign took_nmi   = nmi_q;
  assign push_req   = push_q;
  assign push_data  = push_data_q;
  assign new_pc     = new_pc_q;
  assign vec_fetch  = fetch_q;
  assign entry_cost = cost_q;
  assign pv_flag    = iff2;
  assign int_mode   = mode;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary,
  input logic              ei_exec,
  input logic              retn_exec,
  input logic              taken,
  input logic              took_nmi,
  input logic [ADDR_W-1:0] new_pc,
  input logic [4:0]        entry_cost,
  input logic              iff1,
  input logic              iff2
);
  assert_mask_needs_iff1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !took_nmi) |-> $past(iff1));

  assert_nmi_keeps_iff2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    took_nmi |-> (!iff1 && (iff2 == $past(iff2))));

  assert_nmi_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    took_nmi |-> (new_pc == ADDR_W'(16'h0066) && entry_cost == 5'd11));

  assert_mask_clears_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !took_nmi) |-> (!iff1 && !iff2));

  assert_iff1_rise_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iff1) |-> ($past(ei_exec) || $past(retn_exec)));

  assert_entry_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> $past(boundary));

  assert_nmi_flag_with_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    took_nmi |-> taken);
endmodule

bind irq_accept_ctrl irq_accept_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary   (boundary),
  .ei_exec    (ei_exec),
  .retn_exec  (retn_exec),
  .taken      (taken),
  .took_nmi   (took_nmi),
  .new_pc     (new_pc),
  .entry_cost (entry_cost),
  .iff1       (iff1),
  .iff2       (iff2)
);

// File: tb/irq_accept_ctrl_test.sv
`timescale 1ns/1ps
module irq_accept_ctrl_test;
  localparam int NSRC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic boundary, nmi_req, ei_exec, di_exec, retn_exec, im_set, stop_on_halt;
  logic [NSRC-1:0]   irq_req;
  logic [NSRC*8-1:0] vec_data;
  logic [1:0]  im_value;
  logic [15:0] cur_pc;
  logic [7:0]  cur_opcode, i_reg;
  logic taken, took_nmi, push_req, vec_fetch, iff1, iff2, pv_flag;
  logic [15:0] push_data, new_pc;
  logic [4:0]  entry_cost;
  logic [1:0]  int_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_accept_ctrl uut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi_req(nmi_req),
    .irq_req(irq_req), .vec_data(vec_data), .ei_exec(ei_exec), .di_exec(di_exec),
    .retn_exec(retn_exec), .im_set(im_set), .im_value(im_value), .cur_pc(cur_pc),
    .cur_opcode(cur_opcode), .stop_on_halt(stop_on_halt), .i_reg(i_reg),
    .taken(taken), .took_nmi(took_nmi), .push_req(push_req), .push_data(push_data),
    .new_pc(new_pc), .vec_fetch(vec_fetch), .entry_cost(entry_cost),
    .iff1(iff1), .iff2(iff2), .pv_flag(pv_flag), .int_mode(int_mode)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_irq(input logic [NSRC-1:0] m);
    irq_req = m; cyc(); irq_req = '0;
  endtask
  task automatic pulse_nmi();
    nmi_req = 1'b1; cyc(); nmi_req = 1'b0;
  endtask
  task automatic do_ei();
    ei_exec = 1'b1; cyc(); ei_exec = 1'b0;
  endtask
  task automatic do_di();
    di_exec = 1'b1; cyc(); di_exec = 1'b0;
  endtask
  task automatic do_retn();
    retn_exec = 1'b1; cyc(); retn_exec = 1'b0;
  endtask
  task automatic set_mode(input logic [1:0] v);
    im_set = 1'b1; im_value = v; cyc(); im_set = 1'b0;
  endtask
  task automatic at_boundary(input logic [15:0] pc, input logic [7:0] op);
    cur_pc = pc; cur_opcode = op; boundary = 1'b1; cyc(); boundary = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; boundary = 0; nmi_req = 0; irq_req = '0; ei_exec = 0; di_exec = 0;
    retn_exec = 0; im_set = 0; im_value = 0; cur_pc = '0; cur_opcode = '0;
    stop_on_halt = 0; i_reg = 8'hA5;
    for (int k = 0; k < NSRC; k++) vec_data[k*8 +: 8] = 8'h00;
    repeat (3) cyc();
    chk("R12", "taken in reset", {31'b0, taken}, 32'd0);
    chk("R12", "iff1 in reset", {31'b0, iff1}, 32'd0);
    rst_n = 1'b1;
    repeat (3) cyc();
    chk("R12", "iff2 after reset", {31'b0, iff2}, 32'd0);
    chk("R12", "mode after reset", {30'b0, int_mode}, 32'd0);
    at_boundary(16'h0100, 8'h00);
    chk("R12", "no entry when nothing pending", {31'b0, taken}, 32'd0);

    // R1: masked request waits
    pulse_irq(8'h01);
    at_boundary(16'h0200, 8'h00);
    chk("R1", "masked request not taken", {31'b0, taken}, 32'd0);
    do_ei();
    chk("R6", "ei sets iff1", {31'b0, iff1}, 32'd1);
    chk("R6", "ei sets iff2", {31'b0, iff2}, 32'd1);
    chk("R13", "pv_flag follows iff2", {31'b0, pv_flag}, 32'd1);
    at_boundary(16'h0200, 8'h00);
    chk("R1", "pending request taken after ei", {31'b0, taken}, 32'd1);
    cyc();
    chk("R10", "taken is one cycle", {31'b0, taken}, 32'd0);
    chk("R13", "pv_flag after entry", {31'b0, pv_flag}, 32'd0);
    do_ei();
    do_di();
    chk("R6", "di clears iff1", {31'b0, iff1}, 32'd0);
    chk("R6", "di clears iff2", {31'b0, iff2}, 32'd0);

    // R8/R7/R5 sweep over modes, sources and opcode
    for (int k = 0; k < NSRC; k++) vec_data[k*8 +: 8] = 8'h00;
    for (int m = 0; m < 3; m++) begin
      set_mode(m[1:0]);
      chk("R8", "mode set", {30'b0, int_mode}, m);
      for (int k = 0; k < NSRC; k++) begin
        for (int h = 0; h < 2; h++) begin
          logic [15:0] pc, exp_pc, exp_ret;
          logic [4:0]  exp_cost;
          logic [7:0]  b;
          b = (m == 0) ? {2'b11, k[2:0], 3'b111} : 8'h40 + 8'(k * 2);
          vec_data[k*8 +: 8] = b;
          pc = 16'h1000 + 16'(k * 64 + m * 7 + h);
          exp_ret = (h == 1) ? pc + 16'd1 : pc;
          if (m == 0) begin exp_pc = 16'(k * 8); exp_cost = 5'd13; end
          else if (m == 1) begin exp_pc = 16'h0038; exp_cost = 5'd13; end
          else begin exp_pc = {8'hA5, b}; exp_cost = 5'd19; end
          do_ei();
          pulse_irq(NSRC'(1) << k);
          at_boundary(pc, (h == 1) ? 8'h76 : 8'h00);
          chk("R8", "taken", {31'b0, taken}, 32'd1);
          chk("R10", "push_req", {31'b0, push_req}, 32'd1);
          chk("R8", "new_pc", {16'b0, new_pc}, {16'b0, exp_pc});
          chk("R8", "cost", {27'b0, entry_cost}, {27'b0, exp_cost});
          chk("R8", "vec_fetch", {31'b0, vec_fetch}, (m == 2) ? 32'd1 : 32'd0);
          chk("R7", "return address", {16'b0, push_data}, {16'b0, exp_ret});
          chk("R5", "iff1 cleared", {31'b0, iff1}, 32'd0);
          chk("R5", "iff2 cleared", {31'b0, iff2}, 32'd0);
          vec_data[k*8 +: 8] = 8'h00;
        end
      end
    end
    set_mode(2'd3);
    chk("R8", "mode value 3 ignored", {30'b0, int_mode}, 32'd2);
    set_mode(2'd1);

    // R7: stop_on_halt keeps pc
    stop_on_halt = 1'b1;
    do_ei();
    pulse_irq(8'h01);
    at_boundary(16'h2222, 8'h76);
    chk("R7", "stop_on_halt return", {16'b0, push_data}, 32'h2222);
    stop_on_halt = 1'b0;

    // R9: lowest pending first, only that bit cleared
    set_mode(2'd0);
    for (int k = 0; k < NSRC; k++) vec_data[k*8 +: 8] = {2'b11, k[2:0], 3'b111};
    do_ei();
    pulse_irq(8'b0001_0100);
    at_boundary(16'h0300, 8'h00);
    chk("R9", "lowest source first", {16'b0, new_pc}, 32'h0010);
    do_ei();
    at_boundary(16'h0300, 8'h00);
    chk("R9", "next source kept", {16'b0, new_pc}, 32'h0020);
    do_ei();
    at_boundary(16'h0300, 8'h00);
    chk("R9", "all served", {31'b0, taken}, 32'd0);

    // R2/R3/R4
    do_ei();
    nmi_req = 1'b1; irq_req = 8'h02; cyc(); nmi_req = 1'b0; irq_req = '0;
    at_boundary(16'h0400, 8'h76);
    chk("R2", "nmi wins", {31'b0, took_nmi}, 32'd1);
    chk("R4", "nmi vector", {16'b0, new_pc}, 32'h0066);
    chk("R4", "nmi cost", {27'b0, entry_cost}, 32'd11);
    chk("R7", "nmi return after halt", {16'b0, push_data}, 32'h0401);
    chk("R3", "nmi clears iff1", {31'b0, iff1}, 32'd0);
    chk("R3", "nmi keeps iff2", {31'b0, iff2}, 32'd1);
    at_boundary(16'h0410, 8'h00);
    chk("R3", "no second nmi entry", {31'b0, taken}, 32'd0);
    do_retn();
    chk("R11", "retn restores iff1", {31'b0, iff1}, 32'd1);
    at_boundary(16'h0420, 8'h00);
    chk("R2", "masked request kept pending", {16'b0, new_pc}, 32'h0008);

    // NMI while disabled
    do_di();
    pulse_nmi();
    at_boundary(16'h0500, 8'h00);
    chk("R2", "nmi taken with iff1=0", {31'b0, took_nmi}, 32'd1);
    do_retn();
    chk("R11", "retn copies iff2=0", {31'b0, iff1}, 32'd0);

    // R10: no boundary no entry
    do_ei();
    pulse_irq(8'h80);
    repeat (4) cyc();
    chk("R10", "no entry without boundary", {31'b0, taken}, 32'd0);
    at_boundary(16'h0600, 8'h00);
    chk("R10", "entry at boundary", {31'b0, taken}, 32'd1);
    chk("R9", "source 7 vector", {16'b0, new_pc}, 32'h0038);
    cyc();
    chk("R10", "pulse ends", {31'b0, taken}, 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule